// File: doc/BRIEF.md
# Serial Syndrome Checker for the (7,4) Cyclic Code

This block checks a bit-serial stream of 7-bit blocks coded with the binary cyclic code whose generator is g(X) = X^3 + X + 1. Each received bit enters a three-stage feedback shift register. The register divides the received polynomial r(X) by g(X). When the seventh bit of a block has been taken in, the remainder is latched as the syndrome. An error flag is raised when the syndrome is nonzero, and the divider clears itself for the next block.

The code has minimum distance 3, so any single flipped bit in a block can be located. The block keeps a copy of the seven received bits. One cycle after the syndrome appears, it compares the syndrome with the remainder of each power X^i and emits a corrected word with the matching bit inverted. A zero syndrome means the block is accepted as a codeword and is passed through unchanged.

Bits are admitted only while a block is open. A block opens with a start strobe that comes with its first bit. Idle cycles inside a block pause it. A new start strobe in the middle of a block throws away the partial block.

Top module: `cyclic_syndrome_checker`

## Requirements
- R1: After reset, synValid, corrValid and errFlag are 0, and synOut and corrWord are all zeros.
- R2: Bits are sent with the highest coefficient first (r6 first). Bit j of synOut is the X^j coefficient of r(X) mod (X^3+X+1). synValid is high for exactly one cycle, in the cycle after the clock edge that takes in the seventh bit.
- R3: errFlag is 1 exactly when the latched syndrome is nonzero, and it is updated together with synOut.
- R4: Every one of the 16 codewords m(X)·g(X) gives synOut = 0 and errFlag = 0, and corrWord equals the received word.
- R5: A codeword with bit i inverted (0 ≤ i ≤ 6) gives synOut = X^i mod g(X) and errFlag = 1. corrWord (bit i holds coefficient r_i) equals the original codeword. corrValid pulses for one cycle, one cycle after synValid.
- R6: A bit with inValid high while no block is open and blkStart is low is ignored. It produces no synValid and does not change the syndrome of the next block.
- R7: blkStart with inValid abandons any partial block, and the bit that comes with it is taken as r6 of a new block.
- R8: Cycles with inValid low inside an open block are skipped and do not count toward the seven bits.
- R9: synOut, errFlag and corrWord keep their values until the next block completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A received bit is present on inBit |
| blkStart | input | 1 | With inValid: this bit is the first (r6) of a new block |
| inBit | input | 1 | Received serial bit |
| synOut | output | 3 | Latched syndrome, bit j = X^j coefficient |
| errFlag | output | 1 | Latched syndrome is nonzero |
| synValid | output | 1 | One-cycle pulse: new syndrome latched |
| corrWord | output | 7 | Corrected block, bit i = coefficient of X^i |
| corrValid | output | 1 | One-cycle pulse: corrWord updated |

## Verification
A wrong divider tap or a wrong feedback stage produces a wrong syndrome for some single-bit error. Sweeping all 112 single corruptions therefore exposes it on the syndrome port in the cycle after the seventh bit. A count that drifts, or a divider that is not cleared between blocks, shifts the block boundary. Codewords then stop giving zero syndromes, and the synValid pulse arrives on the wrong cycle, which shows within the first block. A bad correction pattern shows one cycle later as a corrWord that differs from the codeword.

// File: rtl/synchk_pkg.sv
package synchk_pkg;

  typedef struct packed {
    logic shiftEn;   // a bit is admitted into the divider
    logic firstBit;  // admitted bit opens a new block
    logic lastBit;   // admitted bit closes the block
  } strobe_t;

  // Remainder of X^expo divided by the generator (low parLen coefficients).
  function automatic logic [31:0] xPowRem(input int expo, input int parLen,
                                          input logic [31:0] gen);
    logic [31:0] r;
    logic [31:0] lowMask;
    logic fb;
    lowMask = (32'd1 << parLen) - 32'd1;
    r = 32'd1;
    for (int i = 0; i < expo; i++) begin
      fb = r[parLen-1];
      r = (r << 1) & lowMask;
      if (fb) r = r ^ (gen & lowMask);
    end
    return r;
  endfunction

endpackage

// File: rtl/synchk_ctrl.sv
module synchk_ctrl
  import synchk_pkg::*;
#(
  parameter int CW_LEN = 7,
  parameter int CNT_W  = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    blkStart,
  output strobe_t strobe
);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobe.shiftEn  = inValid && (blkStart || active);
    strobe.firstBit = inValid && blkStart;
    strobe.lastBit  = strobe.shiftEn && !blkStart && (cnt == CNT_W'(CW_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (strobe.firstBit) begin
      active <= 1'b1;
      cnt    <= CNT_W'(1);
    end else if (strobe.lastBit) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (strobe.shiftEn) begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

  // R8: the position counter never leaves the block length
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(CW_LEN));

  // R6: with no block open, only a start strobe can open one
  a_r6_closed_stays_closed: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !(inValid && blkStart)) |=> !active);

endmodule

// File: rtl/synchk_dp.sv
module synchk_dp
  import synchk_pkg::*;
#(
  parameter int              CW_LEN   = 7,
  parameter int              PAR_LEN  = 3,
  parameter logic [PAR_LEN:0] GEN_POLY = 4'b1011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inBit,
  input  strobe_t            strobe,
  output logic [PAR_LEN-1:0] synOut,
  output logic               errFlag,
  output logic               synValid,
  output logic [CW_LEN-1:0]  corrWord,
  output logic               corrValid
);

  logic [PAR_LEN-1:0] divReg, divBase, divNext;
  logic [CW_LEN-1:0]  shiftBuf, bufBase, bufNext, wordReg, flipMask;
  logic               fb;

  always_comb begin
    divBase = strobe.firstBit ? '0 : divReg;
    bufBase = strobe.firstBit ? '0 : shiftBuf;
    fb      = divBase[PAR_LEN-1];
    bufNext = {bufBase[CW_LEN-2:0], inBit};
  end

  // divider stage per generator coefficient
  for (genvar j = 0; j < PAR_LEN; j++) begin : g_div
    if (j == 0) begin : g_in
      assign divNext[j] = inBit ^ fb;
    end else begin : g_tap
      assign divNext[j] = divBase[j-1] ^ (fb & GEN_POLY[j]);
    end
  end

  // error-location pattern per bit position
  for (genvar i = 0; i < CW_LEN; i++) begin : g_loc
    localparam logic [PAR_LEN-1:0] LocPat = PAR_LEN'(xPowRem(i, PAR_LEN, 32'(GEN_POLY)));
    assign flipMask[i] = (synOut == LocPat);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg    <= '0;
      shiftBuf  <= '0;
      wordReg   <= '0;
      synOut    <= '0;
      errFlag   <= 1'b0;
      synValid  <= 1'b0;
      corrWord  <= '0;
      corrValid <= 1'b0;
    end else begin
      synValid  <= 1'b0;
      corrValid <= synValid;
      if (strobe.shiftEn) begin
        if (strobe.lastBit) begin
          synOut   <= divNext;
          errFlag  <= |divNext;
          synValid <= 1'b1;
          wordReg  <= bufNext;
          divReg   <= '0;
          shiftBuf <= '0;
        end else begin
          divReg   <= divNext;
          shiftBuf <= bufNext;
        end
      end
      if (synValid) corrWord <= wordReg ^ flipMask;
    end
  end

  // R2: a syndrome only appears right after a closing bit
  a_r2_end_after_last: assert property (@(posedge clk) disable iff (!rstN)
    synValid |-> $past(strobe.lastBit));

  // R5: correction result follows the syndrome by one cycle
  a_r5_corr_follows: assert property (@(posedge clk) disable iff (!rstN)
    synValid |=> corrValid);

  // R4: a clean block passes through unchanged
  a_r4_clean_pass: assert property (@(posedge clk) disable iff (!rstN)
    (corrValid && !errFlag) |-> (corrWord == wordReg));

  // R5: a flagged block has exactly one bit inverted
  a_r5_single_flip: assert property (@(posedge clk) disable iff (!rstN)
    (corrValid && errFlag) |-> ($countones(corrWord ^ wordReg) == 1));

endmodule

// File: rtl/cyclic_syndrome_checker.sv
module cyclic_syndrome_checker
  import synchk_pkg::*;
#(
  parameter int               CW_LEN   = 7,
  parameter int               PAR_LEN  = 3,
  parameter logic [PAR_LEN:0] GEN_POLY = 4'b1011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               blkStart,
  input  logic               inBit,
  output logic [PAR_LEN-1:0] synOut,
  output logic               errFlag,
  output logic               synValid,
  output logic [CW_LEN-1:0]  corrWord,
  output logic               corrValid
);

  localparam int CNT_W = $clog2(CW_LEN);

  strobe_t strobe;

  synchk_ctrl #(.CW_LEN(CW_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .blkStart (blkStart),
    .strobe   (strobe)
  );

  synchk_dp #(.CW_LEN(CW_LEN), .PAR_LEN(PAR_LEN), .GEN_POLY(GEN_POLY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inBit     (inBit),
    .strobe    (strobe),
    .synOut    (synOut),
    .errFlag   (errFlag),
    .synValid  (synValid),
    .corrWord  (corrWord),
    .corrValid (corrValid)
  );

endmodule

// File: tb/cyclic_syndrome_checker_tb.sv
module cyclic_syndrome_checker_tb;

  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       blkStart = 1'b0;
  logic       inBit = 1'b0;
  logic [2:0] synOut;
  logic       errFlag, synValid, corrValid;
  logic [6:0] corrWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  cyclic_syndrome_checker u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .blkStart(blkStart), .inBit(inBit),
    .synOut(synOut), .errFlag(errFlag), .synValid(synValid),
    .corrWord(corrWord), .corrValid(corrValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] encode(input logic [3:0] m);
    logic [6:0] v = '0;
    for (int i = 0; i < 4; i++) if (m[i]) v ^= 7'(7'b0001011 << i);
    return v;
  endfunction

  function automatic logic [2:0] remOf(input logic [6:0] w);
    logic [6:0] r = w;
    for (int d = 6; d >= 3; d--) if (r[d]) r ^= 7'(7'b0001011 << (d - 3));
    return r[2:0];
  endfunction

  // sends r6 first; optional idle cycle before r3; returns at the negedge after the 7th bit's edge
  task automatic sendBlock(input logic [6:0] w, input bit gap);
    for (int i = 6; i >= 0; i--) begin
      if (gap && i == 3) begin
        @(negedge clk); inValid = 1'b0; blkStart = 1'b0;
        chk("R8 no early syndrome", int'(synValid), 0);
      end
      @(negedge clk);
      if (i != 6) chk("R2 no syndrome mid-block", int'(synValid), 0);
      inValid = 1'b1; inBit = w[i]; blkStart = (i == 6);
    end
    @(negedge clk); inValid = 1'b0; blkStart = 1'b0;
  endtask

  task automatic runBlock(input string tag, input logic [6:0] w, input bit gap,
                          input logic [6:0] expWord);
    logic [2:0] es;
    es = remOf(w);
    sendBlock(w, gap);
    chk({tag, " R2 synValid"}, int'(synValid), 1);
    chk({tag, " R2 syndrome"}, int'(synOut), int'(es));
    chk({tag, " R3 errFlag"}, int'(errFlag), int'(es != 3'd0));
    chk({tag, " R5 corrValid early"}, int'(corrValid), 0);
    @(negedge clk);
    chk({tag, " R2 synValid pulse"}, int'(synValid), 0);
    chk({tag, " R5 corrValid"}, int'(corrValid), 1);
    chk({tag, " R5 corrWord"}, int'(corrWord), int'(expWord));
    @(negedge clk);
    chk({tag, " R5 corrValid pulse"}, int'(corrValid), 0);
  endtask

  task automatic testReset();
    chk("R1 synValid", int'(synValid), 0);
    chk("R1 corrValid", int'(corrValid), 0);
    chk("R1 errFlag", int'(errFlag), 0);
    chk("R1 synOut", int'(synOut), 0);
    chk("R1 corrWord", int'(corrWord), 0);
  endtask

  task automatic testCodewords();
    for (int m = 0; m < 16; m++) begin
      logic [6:0] v;
      v = encode(4'(m));
      chk("R4 codeword remainder", int'(remOf(v)), 0);
      runBlock("R4 codeword", v, (m % 5) == 0, v);
    end
  endtask

  task automatic testSingleErrors();
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 7; p++) begin
        logic [6:0] v, r;
        logic [6:0] pw;
        v  = encode(4'(m));
        r  = v ^ (7'd1 << p);
        pw = 7'd1 << p;
        chk("R5 location pattern", int'(remOf(r)), int'(remOf(pw)));
        runBlock("R5 single error", r, (p == 2), v);
      end
    end
  endtask

  task automatic testGate();
    logic [6:0] v;
    v = encode(4'b1011);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); inValid = 1'b1; inBit = 1'b1; blkStart = 1'b0;
    end
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); inValid = (i < 6); inBit = 1'b1;
      chk("R6 stray bits ignored", int'(synValid), 0);
    end
    inValid = 1'b0;
    runBlock("R6 after stray bits", v, 1'b0, v);
  endtask

  task automatic testRestart();
    logic [6:0] v;
    v = encode(4'b0110);
    @(negedge clk); inValid = 1'b1; blkStart = 1'b1; inBit = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); blkStart = 1'b0; inBit = 1'(i);
    end
    runBlock("R7 restart", v, 1'b0, v);
  endtask

  task automatic testHold();
    logic [6:0] v, r;
    v = encode(4'b0101);
    r = v ^ 7'b0010000;
    runBlock("R9 setup", r, 1'b0, v);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 synOut held", int'(synOut), int'(remOf(r)));
      chk("R9 errFlag held", int'(errFlag), 1);
      chk("R9 corrWord held", int'(corrWord), int'(v));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCodewords();
    testSingleErrors();
    testGate();
    testRestart();
    testHold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule